// File: doc/BRIEF.md
# Adaptive Link Mode Controller

This block is the control state machine of a receiver whose carrier frequency is not known in advance. It has two levels. At the outer level it is either sensing the band or receiving. When it enters reception it starts in the strongest error-correction setting. Inside reception it moves between three settings: a long-constraint rate-1/2 convolutional code, a shorter rate-1/2 convolutional code, and no coding at all. The choice follows the measured bit error rate.

While sensing, the controller waits for a candidate frequency from the spectrum estimator and peak detector. It then tunes to that frequency and selects the long-code receive chain. If demodulation never locks, or the signal disappears at any time, it goes back to sensing. While coded, the error-rate sample comes from the decoder. While uncoded, it comes from the deframer's frame error rate. Runs of low samples step the code down to a weaker setting, and runs of high samples step it back up. Two separate thresholds give hysteresis.

Every change of chain raises a reconfiguration request, which stays up until the reconfiguration engine answers. A change between coded settings also sends a one-cycle feedback message, so the transmitter can follow.

Top module: `link_mode_ctrl`

## Requirements
- R1: After reset, chain_sel is 0 (sensing), and tune_freq, reconf_req, fb_valid and rate_x2 are all 0.
- R2: In sensing with no request pending, a cand_valid cycle sets tune_freq to cand_freq, sets chain_sel to 1 (long code) and raises reconf_req, all on the next clock edge.
- R3: While reconf_req is high, every input except reconf_done is ignored. A reconf_done cycle drops reconf_req on the next edge.
- R4: At the edge that clears reconf_req, a settle counter loads settle_len. Error-rate samples are ignored on the settle_len following edges.
- R5: In reception, lock_fail before any lock_ok of the current visit returns chain_sel to 0 and raises reconf_req.
- R6: In reception, sig_lost returns chain_sel to 0 and raises reconf_req, whatever the inner setting. It takes priority over error-rate adaptation.
- R7: QUAL_N consecutive accepted samples strictly below thr_lo step chain_sel one setting weaker (1 to 2, 2 to 3). At the same edge reconf_req rises and fb_valid pulses for one cycle, with fb_mode equal to the new chain_sel.
- R8: QUAL_N consecutive accepted samples strictly above thr_hi step chain_sel one setting stronger (3 to 2, 2 to 1), with the same request and feedback pulse as R7.
- R9: In chain_sel 1 and 2, samples come only from dec_valid/dec_ber. In chain_sel 3 they come only from fer_valid/fer_ber. A sample on the unused source neither counts nor breaks a run.
- R10: An accepted sample inside [thr_lo, thr_hi] clears both runs. A sample in the opposite direction clears the other run.
- R11: rate_x2 is high exactly when chain_sel is 3 (uncoded, double payload rate).
- R12: No error-rate step happens in a reception visit until lock_ok has been seen in that visit.
- R13: A low sample while uncoded, or a high sample while on the long code, counts as an in-band sample (no step beyond the ends).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Sensing found a candidate frequency |
| cand_freq | input | FREQ_W | Candidate frequency word |
| lock_ok | input | 1 | Demodulator achieved lock |
| lock_fail | input | 1 | Demodulator failed to lock |
| sig_lost | input | 1 | Received signal has vanished |
| dec_valid | input | 1 | Decoder error-rate sample strobe |
| dec_ber | input | BER_W | Decoder error-rate estimate |
| fer_valid | input | 1 | Deframer error-rate sample strobe |
| fer_ber | input | BER_W | Error rate derived from frame errors |
| thr_lo | input | BER_W | Lower threshold (step weaker) |
| thr_hi | input | BER_W | Upper threshold (step stronger) |
| settle_len | input | SETTLE_W | Cycles of ignored samples after reconfiguration |
| reconf_done | input | 1 | Reconfiguration engine finished |
| tune_freq | output | FREQ_W | Front-end tune frequency |
| chain_sel | output | 2 | 0 sensing, 1 long code, 2 short code, 3 uncoded |
| reconf_req | output | 1 | Reconfiguration request, held until done |
| fb_valid | output | 1 | One-cycle feedback message strobe to the transmitter |
| fb_mode | output | 2 | Coding setting carried by the feedback message |
| rate_x2 | output | 1 | Payload rate doubled (uncoded) |

## Verification
The assertions assume that reconf_done arrives only while a request is pending. They also assume that status strobes are single-cycle and that thr_lo is not above thr_hi. The stimulus keeps within these limits: it pulses reconf_done only after it has observed reconf_req high, and it holds thr_lo at 100 and thr_hi at 400. Error-rate samples are driven on the source that matches the current setting. The exception is a few deliberate samples on the unused source, which test that source selection ignores them.

// File: rtl/link_mode_ctrl.sv
module link_mode_ctrl #(
  parameter int FREQ_W   = 16,
  parameter int BER_W    = 12,
  parameter int SETTLE_W = 8,
  parameter int QUAL_N   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cand_valid,
  input  logic [FREQ_W-1:0]   cand_freq,
  input  logic                lock_ok,
  input  logic                lock_fail,
  input  logic                sig_lost,
  input  logic                dec_valid,
  input  logic [BER_W-1:0]    dec_ber,
  input  logic                fer_valid,
  input  logic [BER_W-1:0]    fer_ber,
  input  logic [BER_W-1:0]    thr_lo,
  input  logic [BER_W-1:0]    thr_hi,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                reconf_done,
  output logic [FREQ_W-1:0]   tune_freq,
  output logic [1:0]          chain_sel,
  output logic                reconf_req,
  output logic                fb_valid,
  output logic [1:0]          fb_mode,
  output logic                rate_x2
);
  localparam int QW = (QUAL_N < 2) ? 1 : $clog2(QUAL_N);
  localparam logic [QW-1:0] LAST = QW'(QUAL_N - 1);
  localparam logic [1:0] SENSE = 2'd0, LONGK = 2'd1, SHORTK = 2'd2, UNCOD = 2'd3;

  logic [1:0]          mode;
  logic                locked, req, fb;
  logic [SETTLE_W-1:0] settle;
  logic [QW-1:0]       dn_cnt, up_cnt;
  logic [FREQ_W-1:0]   freq;

  wire             in_rx   = mode != SENSE;
  wire             uncoded = mode == UNCOD;
  wire             smp_v   = uncoded ? fer_valid : dec_valid;
  wire [BER_W-1:0] smp     = uncoded ? fer_ber : dec_ber;
  wire             adapt   = locked && settle == '0 && smp_v;
  wire             is_lo   = smp < thr_lo && mode != UNCOD;
  wire             is_hi   = smp > thr_hi && mode != LONGK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= SENSE;
      locked <= 1'b0;
      req    <= 1'b0;
      fb     <= 1'b0;
      settle <= '0;
      dn_cnt <= '0;
      up_cnt <= '0;
      freq   <= '0;
    end else begin
      fb <= 1'b0;
      if (settle != '0) settle <= settle - 1'b1;
      if (req) begin
        if (reconf_done) begin
          req    <= 1'b0;
          settle <= settle_len;
        end
      end else if (!in_rx) begin
        if (cand_valid) begin
          freq   <= cand_freq;
          mode   <= LONGK;
          locked <= 1'b0;
          req    <= 1'b1;
          dn_cnt <= '0;
          up_cnt <= '0;
        end
      end else if (sig_lost || (lock_fail && !locked)) begin
        mode   <= SENSE;
        locked <= 1'b0;
        req    <= 1'b1;
        dn_cnt <= '0;
        up_cnt <= '0;
      end else begin
        if (lock_ok) locked <= 1'b1;
        if (adapt) begin
          if (is_lo) begin
            up_cnt <= '0;
            if (dn_cnt == LAST) begin
              mode   <= mode + 2'd1;
              req    <= 1'b1;
              fb     <= 1'b1;
              dn_cnt <= '0;
            end else dn_cnt <= dn_cnt + 1'b1;
          end else if (is_hi) begin
            dn_cnt <= '0;
            if (up_cnt == LAST) begin
              mode   <= mode - 2'd1;
              req    <= 1'b1;
              fb     <= 1'b1;
              up_cnt <= '0;
            end else up_cnt <= up_cnt + 1'b1;
          end else begin
            dn_cnt <= '0;
            up_cnt <= '0;
          end
        end
      end
    end
  end

  assign tune_freq  = freq;
  assign chain_sel  = mode;
  assign reconf_req = req;
  assign fb_valid   = fb;
  assign fb_mode    = mode;
  assign rate_x2    = uncoded;

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req && !reconf_done |=> reconf_req && $stable(chain_sel) && $stable(tune_freq)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req && reconf_done |=> !reconf_req); // R3
  AST_ENTER_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    chain_sel == SENSE && !reconf_req && cand_valid |=> chain_sel == LONGK && reconf_req); // R2
  AST_LOST_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    chain_sel != SENSE && !reconf_req && sig_lost |=> chain_sel == SENSE && reconf_req); // R6
  AST_FB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> reconf_req && chain_sel != SENSE ##1 !fb_valid); // R7
  AST_INNER_STEP_FB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chain_sel) && $past(chain_sel) != SENSE && chain_sel != SENSE |-> fb_valid); // R8
endmodule

// File: tb/tb_link_mode_ctrl.sv
module tb_link_mode_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cand_valid = 0, lock_ok = 0, lock_fail = 0, sig_lost = 0;
  logic dec_valid = 0, fer_valid = 0, reconf_done = 0;
  logic [15:0] cand_freq = '0;
  logic [11:0] dec_ber = '0, fer_ber = '0, thr_lo = 12'd100, thr_hi = 12'd400;
  logic [7:0]  settle_len = '0;
  logic [15:0] tune_freq;
  logic [1:0]  chain_sel, fb_mode;
  logic        reconf_req, fb_valid, rate_x2;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  link_mode_ctrl dut (.clk, .rst_n, .cand_valid, .cand_freq, .lock_ok, .lock_fail, .sig_lost,
    .dec_valid, .dec_ber, .fer_valid, .fer_ber, .thr_lo, .thr_hi, .settle_len, .reconf_done,
    .tune_freq, .chain_sel, .reconf_req, .fb_valid, .fb_mode, .rate_x2);

  // fields: done | dv | dber[12] | fv | fber[12] | exp_sel[2] | exp_req | exp_fb
  localparam int NV = 29;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd1,1'b0,1'b0},
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd1,1'b0,1'b0},
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd2,1'b1,1'b1},
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd2,1'b1,1'b0},
    {1'b1,1'b0,12'd0  ,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd250,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd250,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b0,12'd0  ,1'b1,12'd500,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd50 ,1'b0,12'd0  ,2'd3,1'b1,1'b1},
    {1'b1,1'b0,12'd0  ,1'b0,12'd0  ,2'd3,1'b0,1'b0},
    {1'b0,1'b1,12'd500,1'b0,12'd0  ,2'd3,1'b0,1'b0},
    {1'b0,1'b0,12'd0  ,1'b1,12'd500,2'd3,1'b0,1'b0},
    {1'b0,1'b0,12'd0  ,1'b1,12'd500,2'd3,1'b0,1'b0},
    {1'b0,1'b0,12'd0  ,1'b1,12'd50 ,2'd3,1'b0,1'b0},
    {1'b0,1'b0,12'd0  ,1'b1,12'd500,2'd3,1'b0,1'b0},
    {1'b0,1'b0,12'd0  ,1'b1,12'd500,2'd3,1'b0,1'b0},
    {1'b0,1'b0,12'd0  ,1'b1,12'd500,2'd2,1'b1,1'b1},
    {1'b1,1'b0,12'd0  ,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd500,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd500,1'b0,12'd0  ,2'd2,1'b0,1'b0},
    {1'b0,1'b1,12'd500,1'b0,12'd0  ,2'd1,1'b1,1'b1},
    {1'b1,1'b0,12'd0  ,1'b0,12'd0  ,2'd1,1'b0,1'b0},
    {1'b0,1'b1,12'd500,1'b0,12'd0  ,2'd1,1'b0,1'b0},
    {1'b0,1'b1,12'd500,1'b0,12'd0  ,2'd1,1'b0,1'b0},
    {1'b0,1'b1,12'd500,1'b0,12'd0  ,2'd1,1'b0,1'b0}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic done_pulse();
    reconf_done = 1; tick(); reconf_done = 0;
  endtask

  task automatic low_dec(input int n);
    for (int k = 0; k < n; k++) begin
      dec_valid = 1; dec_ber = 12'd20; tick();
    end
    dec_valid = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; @(negedge clk);
    chk("R1 chain_sel", 32'(chain_sel), 0);
    chk("R1 reconf_req", 32'(reconf_req), 0);
    chk("R1 tune_freq", 32'(tune_freq), 0);
    chk("R1 fb_valid/rate_x2", {fb_valid, rate_x2}, 0);

    cand_valid = 1; cand_freq = 16'h1234; tick(); cand_valid = 0;
    chk("R2 tune_freq", 32'(tune_freq), 32'h1234);
    chk("R2 chain_sel", 32'(chain_sel), 1);
    chk("R2 reconf_req", 32'(reconf_req), 1);

    lock_fail = 1; tick(); lock_fail = 0;
    chk("R3 lock_fail ignored while pending", 32'(chain_sel), 1);
    done_pulse();
    chk("R3 done clears request", 32'(reconf_req), 0);

    lock_fail = 1; tick(); lock_fail = 0;
    chk("R5 lock_fail to sensing", 32'(chain_sel), 0);
    chk("R5 request raised", 32'(reconf_req), 1);
    cand_valid = 1; cand_freq = 16'h5555; tick(); cand_valid = 0;
    chk("R3 candidate ignored while pending", 32'(tune_freq), 32'h1234);
    done_pulse();

    cand_valid = 1; cand_freq = 16'h2222; tick(); cand_valid = 0;
    chk("R2 second candidate", 32'(tune_freq), 32'h2222);
    done_pulse();
    low_dec(4);
    chk("R12 no step before lock", 32'(chain_sel), 1);
    lock_ok = 1; tick(); lock_ok = 0;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      reconf_done = v[30]; dec_valid = v[29]; dec_ber = v[28:17];
      fer_valid = v[16]; fer_ber = v[15:4];
      tick();
      reconf_done = 0; dec_valid = 0; fer_valid = 0;
      chk($sformatf("R7/R8/R9/R10/R13 vec %0d chain_sel", i), 32'(chain_sel), 32'(v[3:2]));
      chk($sformatf("R3 vec %0d reconf_req", i), 32'(reconf_req), 32'(v[1]));
      chk($sformatf("R7 vec %0d fb_valid", i), 32'(fb_valid), 32'(v[0]));
    end

    settle_len = 8'd4;
    low_dec(2);
    dec_valid = 1; dec_ber = 12'd20; tick(); dec_valid = 0;
    chk("R7 step to short code", 32'(chain_sel), 2);
    chk("R7 fb_mode", 32'(fb_mode), 2);
    chk("R7 fb_valid", 32'(fb_valid), 1);
    done_pulse();
    low_dec(6);
    chk("R4 settle ignores samples", 32'(chain_sel), 2);
    low_dec(1);
    chk("R4 first sample after settle counts", 32'(chain_sel), 3);
    done_pulse();
    chk("R11 rate_x2 when uncoded", 32'(rate_x2), 1);

    sig_lost = 1; tick(); sig_lost = 0;
    chk("R6 sig_lost from uncoded", 32'(chain_sel), 0);
    chk("R6 request raised", 32'(reconf_req), 1);
    chk("R11 rate_x2 cleared", 32'(rate_x2), 0);
    done_pulse();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule